// File: doc/BRIEF.md
# Endpoint Interrupt Mask and Status

This block collects interrupt events from the sixteen endpoints of a USB device controller. It keeps them as sticky status bits and gives the CPU one combined request line. Each endpoint delivers a single-cycle event pulse. The pulse is latched into that endpoint's status bit only when the endpoint's mask bit is clear. The mask therefore gates the setting of status bits, not the request output. A bit that is already pending stays visible and keeps the request asserted, whatever happens to its mask afterwards.

Software uses a small register port: a write strobe, a 2-bit register index, 32-bit write data and combinational 32-bit read data. There are four 8-bit registers. Two hold the mask bits and two hold the status bits. Each pair is split between endpoints 0–7 and endpoints 8–15. Status bits are cleared by writing a 1 to them.

Top module: `ep_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every status bit is 0 and `irq_o` is 0.
- R2: While an endpoint's mask bit is 1, an event on that endpoint does not set its status bit.
- R3: While an endpoint's mask bit is 0, an event on that endpoint sets its status bit at the next rising clock edge.
- R4: Writing a mask bit to 1 does not change a status bit that is already set, and `irq_o` stays asserted.
- R5: Writing a 1 to a status bit clears it at the next edge. Writing a 0 to a status bit leaves it unchanged.
- R6: When a clear and an unmasked event hit the same status bit in the same cycle, the bit stays set.
- R7: `irq_o` equals the OR of all sixteen status bits as they were one clock earlier.
- R8: The register index selects 0 = mask for endpoints 0–7, 1 = mask for endpoints 8–15, 2 = status for endpoints 0–7, 3 = status for endpoints 8–15. Endpoint n sits in bit n mod 8. Read data follows the index in the same cycle.
- R9: Data bits 31:8 of every register read as zero, and write data in those bits has no effect.
- R10: An event that arrives in the same cycle as a mask write is gated by the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ep_evt_i | input | 16 | Per-endpoint event pulses, bit n for endpoint n |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The bench goes after the same-cycle races. In one, a clear meets a new event; a design that let the clear win would lose that interrupt. In another, a mask write meets an event in both directions; a design that used the new mask value would set a bit that should have been blocked, or drop one that should have been caught. It also masks an endpoint whose status bit is already pending. A design that gated the output, or cleared status on masking, would then lower `irq_o`. Further checks catch a request line that is off by one cycle, and upper data bits that either leak into reads or reach the registers through writes.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  parameter int unsigned EP_NUM = 16;
  parameter int unsigned EP_REG_W = 8;
  parameter int unsigned EP_BUS_W = 32;
endpackage

// File: rtl/ep_irq_mask_bank.sv
module ep_irq_mask_bank #(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NUM_EP-1:0] mask_o
);
  localparam int unsigned NUM_GRP = NUM_EP / REG_W;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [IDX_W-1:0] SEL = IDX_W'(g);
    logic [REG_W-1:0] mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   mask_q <= '1;
      else if (we_i && idx_i == SEL) mask_q <= wdata_i;
    end

    assign mask_o[g*REG_W +: REG_W] = mask_q;
  end
endmodule

// File: rtl/ep_irq_status.sv
module ep_irq_status #(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] evt_i,
  input  logic [NUM_EP-1:0] mask_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NUM_EP-1:0] stat_o
);
  localparam int unsigned NUM_GRP = NUM_EP / REG_W;

  logic [NUM_EP-1:0] clr;
  logic [NUM_EP-1:0] set;
  logic [NUM_EP-1:0] stat_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_clr
    localparam logic [IDX_W-1:0] SEL = IDX_W'(NUM_GRP + g);
    assign clr[g*REG_W +: REG_W] = (we_i && idx_i == SEL) ? wdata_i : '0;
  end

  // mask_i is the registered mask, so a same-cycle mask write is not yet seen
  assign set = evt_i & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | set;
  end

  assign stat_o = stat_q;

  // R2
  a_r2_masked_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(mask_i)) == '0));
  // R3 and R6
  a_r3_unmasked_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(evt_i & ~mask_i)) == $past(evt_i & ~mask_i)));
  // R4 and R5: only a written 1 removes a pending bit
  a_r5_hold_unless_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~stat_q & $past(stat_q & ~clr)) == '0));
  // R5
  a_r5_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(clr & ~(evt_i & ~mask_i))) == '0));
endmodule

// File: rtl/ep_irq_rdmux.sv
module ep_irq_rdmux #(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [NUM_EP-1:0] mask_i,
  input  logic [NUM_EP-1:0] stat_i,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int unsigned NUM_GRP = NUM_EP / REG_W;

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (idx_i == IDX_W'(g))           rdata_o[REG_W-1:0] = mask_i[g*REG_W +: REG_W];
      if (idx_i == IDX_W'(NUM_GRP + g)) rdata_o[REG_W-1:0] = stat_i[g*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl
  import ep_irq_pkg::*;
#(
  parameter int unsigned NUM_EP = EP_NUM,
  parameter int unsigned REG_W  = EP_REG_W,
  parameter int unsigned BUS_W  = EP_BUS_W,
  localparam int unsigned NUM_GRP = NUM_EP / REG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_GRP) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] ep_evt_i,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_EP-1:0] mask;
  logic [NUM_EP-1:0] stat;
  logic              irq_q;
  logic              unused_wdata_hi;

  // reserved write bits are dropped here
  assign unused_wdata_hi = ^reg_wdata_i[BUS_W-1:REG_W];

  ep_irq_mask_bank #(.NUM_EP(NUM_EP), .REG_W(REG_W), .IDX_W(IDX_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i[REG_W-1:0]),
    .mask_o  (mask)
  );

  ep_irq_status #(.NUM_EP(NUM_EP), .REG_W(REG_W), .IDX_W(IDX_W)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (ep_evt_i),
    .mask_i  (mask),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i[REG_W-1:0]),
    .stat_o  (stat)
  );

  ep_irq_rdmux #(.NUM_EP(NUM_EP), .REG_W(REG_W), .BUS_W(BUS_W), .IDX_W(IDX_W)) u_rdmux (
    .idx_i   (reg_idx_i),
    .mask_i  (mask),
    .stat_i  (stat),
    .rdata_o (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |stat;
  end

  assign irq_o = irq_q;

  // R7
  a_r7_irq_follows_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|stat)));
  // R9
  a_r9_upper_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[BUS_W-1:REG_W] == '0);
endmodule

// File: tb/ep_irq_ctrl_tb.sv
module ep_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        we = 1'b0;
  logic [1:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ep_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ep_evt_i(evt), .reg_we_i(we),
    .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [1:0] i, logic [31:0] exp);
    idx = i;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wr(logic [1:0] i, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(logic [15:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    rd("R1 mask lo", 2'd0, 32'h0000_00FF);
    rd("R1 mask hi", 2'd1, 32'h0000_00FF);
    rd("R1 stat lo", 2'd2, 32'h0);
    rd("R1 stat hi", 2'd3, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_masked();
    pulse(16'hFFFF);
    rd("R2 stat lo", 2'd2, 32'h0);
    rd("R2 stat hi", 2'd3, 32'h0);
    @(negedge clk);
    check("R2 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_unmask_set();
    wr(2'd0, 32'h0000_00FE);
    wr(2'd1, 32'h0000_007F);
    rd("R8 mask hi", 2'd1, 32'h0000_007F);
    pulse(16'hFFFF);
    rd("R3 stat lo ep0", 2'd2, 32'h0000_0001);
    rd("R8 stat hi ep15", 2'd3, 32'h0000_0080);
    check("R7 irq lags one cycle", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq high", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_mask_keeps();
    wr(2'd0, 32'h0000_00FF);
    wr(2'd1, 32'h0000_00FF);
    rd("R4 stat lo kept", 2'd2, 32'h0000_0001);
    rd("R4 stat hi kept", 2'd3, 32'h0000_0080);
    check("R4 irq kept", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_w1c();
    wr(2'd2, 32'h0);
    rd("R5 write 0 no effect", 2'd2, 32'h0000_0001);
    wr(2'd2, 32'h0000_0001);
    rd("R5 clear lo", 2'd2, 32'h0);
    rd("R5 hi untouched", 2'd3, 32'h0000_0080);
    wr(2'd3, 32'h0000_0080);
    rd("R5 clear hi", 2'd3, 32'h0);
    check("R7 irq still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R7 irq falls", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear_race();
    wr(2'd0, 32'h0000_00FE);
    pulse(16'h0001);
    rd("R3 ep0 set", 2'd2, 32'h0000_0001);
    @(negedge clk);
    we = 1'b1; idx = 2'd2; wdata = 32'h1; evt = 16'h0001;
    @(negedge clk);
    we = 1'b0; wdata = '0; evt = '0;
    rd("R6 event beats clear", 2'd2, 32'h0000_0001);
    wr(2'd2, 32'h1);
    rd("R5 cleared after race", 2'd2, 32'h0);
  endtask

  task automatic t_mask_race();
    // ep1 masked before the write, unmasked by it: event blocked
    @(negedge clk);
    we = 1'b1; idx = 2'd0; wdata = 32'h0000_00FC; evt = 16'h0002;
    @(negedge clk);
    we = 1'b0; wdata = '0; evt = '0;
    rd("R10 old mask blocks", 2'd2, 32'h0);
    pulse(16'h0002);
    rd("R3 ep1 set", 2'd2, 32'h0000_0002);
    // ep0 unmasked before the write, masked by it: event caught
    @(negedge clk);
    we = 1'b1; idx = 2'd0; wdata = 32'h0000_00FF; evt = 16'h0001;
    @(negedge clk);
    we = 1'b0; wdata = '0; evt = '0;
    rd("R10 old mask passes", 2'd2, 32'h0000_0003);
    wr(2'd2, 32'h3);
    rd("R5 cleared both", 2'd2, 32'h0);
  endtask

  task automatic t_reserved();
    wr(2'd1, 32'hFFFF_FF00);
    rd("R9 mask hi upper ignored", 2'd1, 32'h0);
    pulse(16'h0100);
    rd("R9 stat hi upper zero", 2'd3, 32'h0000_0001);
    wr(2'd3, 32'hFFFF_FF00);
    rd("R9 clear upper ignored", 2'd3, 32'h0000_0001);
    wr(2'd3, 32'h1);
    wr(2'd1, 32'hFF);
    rd("R9 mask restored", 2'd1, 32'h0000_00FF);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_unmask_set();
        t_mask_keeps();
        t_w1c();
        t_clear_race();
        t_mask_race();
        t_reserved();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_err++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule